// File: doc/BRIEF.md
# DRAM Refresh and Start-up Scheduler

This block keeps an asynchronous DRAM alive on behalf of the access sequencer that normally drives its strobes. When reset ends, it keeps the memory idle for a programmable power-up pause. It then runs a programmable number of warm-up refresh cycles. Only after those complete does it raise `ready`, which tells the sequencer that normal accesses may begin.

From then on, a free-running interval timer asks for one refresh per interval. The interval is chosen so that every row is visited within the refresh period. For example, at 50 MHz an interval of 780 clocks gives 1024 refreshes in under 16 ms. Each refresh uses column-before-row ordering, so the device supplies the row address itself.

The block asks for the strobes with `ref_req`. It uses them only after `ref_gnt`, and flags `own` while it drives them. The sequencer must keep `ref_gnt` high while `ref_req` is high, and must route this block's strobes to the memory while `own` is high. When `own` is low, the block's strobes sit inactive (high). If a second interval expires while a refresh is still waiting for its grant, a sticky `err` is raised. The missed refresh is kept and issued as well.

Top module: `dref_sched`

## Requirements
- R1: During reset `ref_req`, `own`, `ready` and `err` are 0, and `ras_n`, both bits of `cas_n`, and `we_n` are 1.
- R2: After reset is released, `ref_req` stays 0 for at least PAUSE_CYC clocks and rises no later than PAUSE_CYC+2 clocks.
- R3: Exactly INIT_CNT refresh cycles run before `ready`. `ready` is 0 when the first INIT_CNT-1 of them end, is 1 from the end of the INIT_CNT-th, and never falls again.
- R4: `ref_req` stays high until `ref_gnt` is seen. `own` rises only after a cycle with `ref_gnt` high. While the grant is withheld, `own` stays 0 and the strobes stay high. A strobe is low only while `own` is 1.
- R5: Each refresh starts with T_RP clocks in which it owns the strobes with both high. Then both `cas_n` bits are low for T_CSR clocks while `ras_n` is still high.
- R6: `ras_n` is then low for T_RAS clocks, and `cas_n` stays low for the first T_CHR of them. After that, T_RP clocks of ownership follow with both strobes high before `own` falls.
- R7: `we_n` is 1 throughout every refresh, and both `cas_n` bits always carry the same value.
- R8: Once `ready` is 1 and grants are immediate, successive rising edges of `ref_req` are exactly INTERVAL clocks apart.
- R9: If the interval expires while a refresh is still waiting for its grant, `err` becomes 1 and stays 1 until reset. It is 0 before that second expiry.
- R10: A refresh whose grant is delayed is not dropped. After an overdue episode, the grant produces two complete refresh cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Sequencer hands the strobes over to this block |
| ref_req | output | 1 | Refresh wanted; held until the cycle completes |
| own | output | 1 | This block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes for both byte lanes, active low |
| we_n | output | 1 | Write enable, held inactive |
| ready | output | 1 | Start-up pause and warm-up refreshes are done |
| err | output | 1 | Sticky: a refresh became overdue twice |

## Verification
The hardest state to reach is the overdue backlog: a refresh must stay ungranted across a full interval, so that a second request piles onto the first. The bench model of the access sequencer normally grants at once. After the periodic spacing has been measured, it stops granting and waits for the next request. It then checks `err` just before and just after the following interval boundary, confirms that the strobes stayed untouched, and releases the grant. The scoreboard must then see two full refresh cycles, each with correct strobe timing.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_PRE,
    SQ_CSR,
    SQ_RAS,
    SQ_END
  } seq_st_e;
endpackage

// File: rtl/dref_interval.sv
module dref_interval #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic served,
  output logic pend_any,
  output logic err
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] timer;
  logic [1:0]    pend;
  logic          tick;

  assign tick     = en && (timer == TW'(INTERVAL - 1));
  assign pend_any = (pend != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= '0;
    end else if (!en || tick) begin
      timer <= '0;
    end else begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 2'd0;
      err  <= 1'b0;
    end else begin
      if (tick && !served && pend != 2'd3)      pend <= pend + 2'd1;
      else if (!tick && served && pend != 2'd0) pend <= pend - 2'd1;
      if (tick && pend != 2'd0 && !served)      err  <= 1'b1;
    end
  end

  // R9: the overdue flag never clears
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R9: the flag rises only while a refresh was already outstanding
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(pend_any));
endmodule

// File: rtl/dref_cbr_seq.sv
module dref_cbr_seq
  import dref_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_CSR = 1,
  parameter int T_RAS = 4,
  parameter int T_CHR = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic gnt,
  output logic req,
  output logic own,
  output logic ras_n,
  output logic cas_n,
  output logic done
);
  localparam int M1   = (T_RP > T_CSR) ? T_RP : T_CSR;
  localparam int LMAX = (M1 > T_RAS) ? M1 : T_RAS;
  localparam int CW   = $clog2(LMAX + 1);

  seq_st_e       st;
  logic [CW-1:0] cnt;
  logic          seg_last;

  always_comb begin
    case (st)
      SQ_PRE:  seg_last = (cnt == CW'(T_RP - 1));
      SQ_CSR:  seg_last = (cnt == CW'(T_CSR - 1));
      SQ_RAS:  seg_last = (cnt == CW'(T_RAS - 1));
      SQ_END:  seg_last = (cnt == CW'(T_RP - 1));
      default: seg_last = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (want) st <= SQ_WAIT;
        SQ_WAIT: if (gnt) begin
          st  <= SQ_PRE;
          cnt <= '0;
        end
        default: begin
          if (seg_last) begin
            cnt <= '0;
            case (st)
              SQ_PRE:  st <= SQ_CSR;
              SQ_CSR:  st <= SQ_RAS;
              SQ_RAS:  st <= SQ_END;
              default: st <= SQ_IDLE;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign req   = (st != SQ_IDLE);
  assign own   = (st != SQ_IDLE) && (st != SQ_WAIT);
  assign ras_n = (st != SQ_RAS);
  assign cas_n = !((st == SQ_CSR) || ((st == SQ_RAS) && (cnt < CW'(T_CHR))));
  assign done  = (st == SQ_END) && seg_last;

  // R5: the row strobe only falls after the column strobe was already low
  a_r5_cas_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !$past(cas_n));
  // R5: the column strobe falls only with the row strobe precharged
  a_r5_ras_precharged: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (ras_n && $past(ras_n)));
  // R4: strobes are driven low only while owned
  a_r4_strobes_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> own);
  // R4: ownership begins only after a grant
  a_r4_own_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own) |-> $past(gnt));
  // R4: a request that is not yet served is kept
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !own) |=> req);
endmodule

// File: rtl/dref_sched.sv
module dref_sched #(
  parameter int PAUSE_CYC = 10000,
  parameter int INIT_CNT  = 8,
  parameter int INTERVAL  = 780,
  parameter int T_RP      = 3,
  parameter int T_CSR     = 1,
  parameter int T_RAS     = 4,
  parameter int T_CHR     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_gnt,
  output logic       ref_req,
  output logic       own,
  output logic       ras_n,
  output logic [1:0] cas_n,
  output logic       we_n,
  output logic       ready,
  output logic       err
);
  localparam int PW = (PAUSE_CYC > 2) ? $clog2(PAUSE_CYC) : 1;
  localparam int IW = $clog2(INIT_CNT + 1);

  logic [PW-1:0] pcnt;
  logic          pause_done;
  logic [IW-1:0] init_left;
  logic          want;
  logic          seq_done;
  logic          pend_any;
  logic          cas_n_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt       <= '0;
      pause_done <= 1'b0;
    end else if (!pause_done) begin
      if (pcnt == PW'(PAUSE_CYC - 1)) pause_done <= 1'b1;
      else                            pcnt       <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_left <= IW'(INIT_CNT);
      ready     <= 1'b0;
    end else if (seq_done && !ready) begin
      init_left <= init_left - 1'b1;
      if (init_left == IW'(1)) ready <= 1'b1;
    end
  end

  assign want = ready ? pend_any : (pause_done && init_left != '0);

  dref_interval #(.INTERVAL(INTERVAL)) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ready),
    .served   (seq_done && ready),
    .pend_any (pend_any),
    .err      (err)
  );

  dref_cbr_seq #(.T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_CHR(T_CHR)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (want),
    .gnt   (ref_gnt),
    .req   (ref_req),
    .own   (own),
    .ras_n (ras_n),
    .cas_n (cas_n_i),
    .done  (seq_done)
  );

  assign cas_n = {2{cas_n_i}};
  assign we_n  = 1'b1;

  // R2: no request while the power-up pause runs
  a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> !ref_req);
  // R3: ready never falls once set
  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R3: ready rises only at the end of a refresh cycle
  a_r3_ready_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(seq_done));
endmodule

// File: tb/dref_sched_test.sv
module dref_sched_test;
  localparam int PAUSE = 60;
  localparam int INIT  = 8;
  localparam int INTV  = 120;
  localparam int TRP   = 3;
  localparam int TCSR  = 1;
  localparam int TRAS  = 4;
  localparam int TCHR  = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_gnt = 1'b0;
  logic       ref_req, own, ras_n, we_n, ready, err;
  logic [1:0] cas_n;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc = 0;
  bit  allow = 1'b0;
  bit  exp_q[$];
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  dref_sched #(.PAUSE_CYC(PAUSE), .INIT_CNT(INIT), .INTERVAL(INTV),
               .T_RP(TRP), .T_CSR(TCSR), .T_RAS(TRAS), .T_CHR(TCHR)) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .own(own),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready), .err(err));

  task automatic check(bit ok, string rq, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic ncyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rise(output int t);
    while (ref_req) @(negedge clk);
    while (!ref_req) @(negedge clk);
    t = cyc;
  endtask

  initial forever @(posedge clk) if (rst_n) cyc++;

  // sequencer model: grants whenever allowed
  initial forever begin
    @(negedge clk);
    ref_gnt = ref_req && allow;
  end

  // monitor: measures each refresh burst and compares with the scoreboard
  initial begin
    int pre, csr, rlo, chr, post, webad, lanebad;
    bit seen_cas, prev_own;
    pre = 0; csr = 0; rlo = 0; chr = 0; post = 0; webad = 0; lanebad = 0;
    seen_cas = 0; prev_own = 0;
    forever begin
      @(negedge clk);
      if (cas_n[0] != cas_n[1]) lanebad++;
      if (own) begin
        if (!we_n) webad++;
        if (!ras_n) begin
          rlo++;
          if (!cas_n[0]) chr++;
        end else if (!cas_n[0]) begin
          csr++;
          seen_cas = 1;
        end else if (!seen_cas) pre++;
        else post++;
      end else if (prev_own) begin
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected refresh", 1, 0);
        end else begin
          bit er;
          er = exp_q.pop_front();
          check(ready == er, "R3 ready at cycle end", int'(ready), int'(er));
          check(pre == TRP, "R5 precharge before cas", pre, TRP);
          check(csr == TCSR, "R5 cas setup", csr, TCSR);
          check(rlo == TRAS, "R6 ras low width", rlo, TRAS);
          check(chr == TCHR, "R6 cas hold", chr, TCHR);
          check(post == TRP, "R6 trailing precharge", post, TRP);
          check(webad == 0, "R7 we_n high", webad, 0);
          check(lanebad == 0, "R7 lanes equal", lanebad, 0);
        end
        pre = 0; csr = 0; rlo = 0; chr = 0; post = 0; webad = 0; lanebad = 0;
        seen_cas = 0;
      end
      prev_own = own;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, t1, t2, t3;
    ncyc(4);
    // R1 reset state
    check(ref_req == 0 && own == 0, "R1 req/own in reset", int'(ref_req | own), 0);
    check(ready == 0 && err == 0, "R1 ready/err in reset", int'(ready | err), 0);
    check(ras_n && cas_n == 2'b11 && we_n, "R1 strobes in reset", int'({ras_n, cas_n, we_n}), 15);
    allow = 1;
    for (int i = 0; i < INIT; i++) exp_q.push_back(i == INIT - 1);
    rst_n = 1'b1;
    // R2 pause
    wait_rise(t0);
    check(t0 >= PAUSE && t0 <= PAUSE + 2, "R2 first request after pause", t0, PAUSE + 1);
    while (!ready) @(negedge clk);
    check(exp_q.size() == 0, "R3 warm-up count", exp_q.size(), 0);
    // R8 periodic spacing
    for (int i = 0; i < 3; i++) exp_q.push_back(1'b1);
    wait_rise(t1);
    wait_rise(t2);
    check(t2 - t1 == INTV, "R8 interval spacing", t2 - t1, INTV);
    wait_rise(t3);
    check(t3 - t2 == INTV, "R8 interval spacing", t3 - t2, INTV);
    ncyc(20);
    check(err == 0, "R9 no error in normal run", int'(err), 0);
    // R9/R10 overdue episode
    allow = 0;
    exp_q.push_back(1'b1);
    exp_q.push_back(1'b1);
    wait_rise(t1);
    ncyc(INTV - 5);
    check(err == 0, "R9 no error before second expiry", int'(err), 0);
    check(ref_req == 1 && own == 0, "R4 request held, not owned", int'({ref_req, own}), 2);
    check(ras_n && cas_n == 2'b11, "R4 strobes idle without grant", int'({ras_n, cas_n}), 7);
    ncyc(8);
    check(err == 1, "R9 error after second expiry", int'(err), 1);
    allow = 1;
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R10 both refreshes issued", exp_q.size(), 0);
    ncyc(5);
    check(err == 1, "R9 error sticky", int'(err), 1);
    check(ready == 1, "R3 ready stays high", int'(ready), 1);
    finish_run();
  end
endmodule